// File: doc/BRIEF.md
# Dual-Level Power Throttle Monitor

The monitor receives a periodic total-power reading in watts, qualified by a valid strobe. It compares every reading against two programmable throttle points. The lower point drives a mild throttle, which asks the clocking logic to drop one frequency bin, roughly 100 MHz. The upper point drives a severe throttle, which forces the lowest operating frequency, roughly 600 MHz. Each level must see power above its point on a run of consecutive readings before it engages. Each level then stays engaged until power falls through its own hysteresis band, so the card does not cycle between throttled and normal operation.

The mild band is 15 W for the standard TDP class and 20 W for the high (300 W) class. The severe band is 40 W. Once the severe throttle has held for a programmed number of readings, the block also asks for a lower core voltage. That request drops in the same cycle that the severe throttle lets go. The throttle points only mark where throttling starts and do not alter the card's TDP. Typical settings are 105 % of TDP for the mild point with a dwell equal to 300 ms of readings, 125 % of TDP for the severe point with a 50 ms dwell, and a voltage delay of 300 to 400 ms of readings.

Top module: `pwr_throttle_mon`

## Requirements
- R1: A synchronous reset (rst high on a clock edge) clears both levels, both dwell timers and the voltage timer. After reset mild_on, sev_on and vdrop_req are 0 and freq_req is 2'b00.
- R2: mild_on rises in the cycle after the valid reading that completes cfg_mild_dwell consecutive valid readings strictly above cfg_mild_thr.
- R3: When mild_on is high, it falls after a valid reading at or below cfg_mild_thr−15 (cfg_tdp_hi=0) or cfg_mild_thr−20 (cfg_tdp_hi=1). It stays high after any valid reading above that point. A negative release point counts as 0.
- R4: sev_on rises in the cycle after the valid reading that completes cfg_sev_dwell consecutive valid readings strictly above cfg_sev_thr.
- R5: When sev_on is high, it falls after a valid reading at or below cfg_sev_thr−40 and stays high after any valid reading above that point.
- R6: When a level is inactive, a valid reading at or below its threshold restarts that level's dwell count from zero.
- R7: freq_req is 2'b10 (minimum frequency) whenever sev_on is high, 2'b01 (one bin down) when only mild_on is high, and 2'b00 otherwise.
- R8: vdrop_req rises after cfg_vdrop_dly valid readings taken while sev_on is high, counting from the first reading after sev_on rose. It is low in every cycle in which sev_on is low.
- R9: Cycles with smp_valid low change no timer and no throttle state, whatever smp_pwr is.
- R10: A dwell or delay setting of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Power reading strobe |
| smp_pwr | input | PWR_W | Total power reading, watts |
| cfg_mild_thr | input | PWR_W | Mild throttle point, watts |
| cfg_sev_thr | input | PWR_W | Severe throttle point, watts |
| cfg_mild_dwell | input | DWELL_W | Readings above mild point before engaging |
| cfg_sev_dwell | input | DWELL_W | Readings above severe point before engaging |
| cfg_vdrop_dly | input | DWELL_W | Readings under severe throttle before voltage request |
| cfg_tdp_hi | input | 1 | 1 selects the high TDP class (20 W mild band) |
| mild_on | output | 1 | Mild throttle engaged |
| sev_on | output | 1 | Severe throttle engaged |
| freq_req | output | 2 | Frequency request: 00 nominal, 01 step down, 10 minimum |
| vdrop_req | output | 1 | Core voltage reduction request |

## Verification
The bench builds the block with PWR_W=10 and DWELL_W=5. Dwell and delay counts of a few readings stand in for the real 50, 300 and 400 ms windows, so every assert, hold and release edge can be reached within a few dozen readings. A 10-bit reading covers the 250 to 400 W range, and with it both hysteresis bands and the severe-over-mild priority. Those values also let the bench test a zero dwell and restart a count partway through its run.

// File: rtl/pwr_thr_pkg.sv
package pwr_thr_pkg;

    typedef enum logic [1:0] {
        FREQ_NOMINAL = 2'b00,
        FREQ_STEP    = 2'b01,
        FREQ_MINIMUM = 2'b10
    } freq_req_e;

    localparam int MILD_BAND_STD = 15;
    localparam int MILD_BAND_HI  = 20;
    localparam int SEV_BAND      = 40;

endpackage

// File: rtl/thr_level.sv
module thr_level #(
    parameter int PWR_W   = 10,
    parameter int DWELL_W = 16,
    parameter int BAND_LO = 15,
    parameter int BAND_HI = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [PWR_W-1:0]   pwr,
    input  logic [PWR_W-1:0]   thr,
    input  logic [DWELL_W-1:0] dwell,
    input  logic               band_sel,
    output logic               active
);

    localparam logic [PWR_W-1:0] BAND_LO_V = PWR_W'(BAND_LO);
    localparam logic [PWR_W-1:0] BAND_HI_V = PWR_W'(BAND_HI);

    typedef struct packed {
        logic               act;
        logic [DWELL_W-1:0] cnt;
    } lvl_st_t;

    lvl_st_t s_d, s_q;
    logic [PWR_W-1:0]   band;
    logic [PWR_W-1:0]   rel_pt;
    logic [DWELL_W:0]   need;
    logic [DWELL_W:0]   cnt_inc;

    always_comb begin
        s_d     = s_q;
        band    = band_sel ? BAND_HI_V : BAND_LO_V;
        rel_pt  = (thr > band) ? (thr - band) : '0;
        need    = (dwell == '0) ? (DWELL_W+1)'(1) : {1'b0, dwell};
        cnt_inc = {1'b0, s_q.cnt} + (DWELL_W+1)'(1);
        if (valid) begin
            if (!s_q.act) begin
                if (pwr > thr) begin
                    if (cnt_inc >= need) begin
                        s_d.act = 1'b1;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = cnt_inc[DWELL_W-1:0];
                    end
                end else begin
                    s_d.cnt = '0;
                end
            end else begin
                s_d.cnt = '0;
                if (pwr <= rel_pt) begin
                    s_d.act = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.act;

    // R6: an at-or-below reading while idle leaves the count at zero
    a_r6_timer_clear: assert property (@(posedge clk) disable iff (rst)
        (valid && !s_q.act && pwr <= thr) |=> (!s_q.act && s_q.cnt == '0));

    // R9: idle cycles freeze the level
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid) |=> ($stable(s_q.act) && $stable(s_q.cnt)));

    // R3 / R5: a reading above the release point keeps the level engaged
    a_r3_r5_hold_above: assert property (@(posedge clk) disable iff (rst)
        (valid && s_q.act && pwr > rel_pt) |=> s_q.act);

endmodule

// File: rtl/vdrop_timer.sv
module vdrop_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic               sev_on,
    input  logic [DWELL_W-1:0] dly,
    output logic               req
);

    typedef struct packed {
        logic               hit;
        logic [DWELL_W-1:0] cnt;
    } vd_st_t;

    vd_st_t s_d, s_q;
    logic [DWELL_W:0] need;
    logic [DWELL_W:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        need    = (dly == '0) ? (DWELL_W+1)'(1) : {1'b0, dly};
        cnt_inc = {1'b0, s_q.cnt} + (DWELL_W+1)'(1);
        if (!sev_on) begin
            s_d = '0;
        end else if (valid && !s_q.hit) begin
            if (cnt_inc >= need) begin
                s_d.hit = 1'b1;
            end else begin
                s_d.cnt = cnt_inc[DWELL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req = s_q.hit && sev_on;

    // R8: timer is empty one cycle after the severe level is off
    a_r8_timer_idle: assert property (@(posedge clk) disable iff (rst)
        (!sev_on) |=> (s_q.cnt == '0 && !s_q.hit));

    // R8: request only rises on a valid reading
    a_r8_rise_on_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.hit) |-> $past(valid));

endmodule

// File: rtl/pwr_throttle_mon.sv
module pwr_throttle_mon
    import pwr_thr_pkg::*;
#(
    parameter int PWR_W   = 10,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [PWR_W-1:0]   smp_pwr,
    input  logic [PWR_W-1:0]   cfg_mild_thr,
    input  logic [PWR_W-1:0]   cfg_sev_thr,
    input  logic [DWELL_W-1:0] cfg_mild_dwell,
    input  logic [DWELL_W-1:0] cfg_sev_dwell,
    input  logic [DWELL_W-1:0] cfg_vdrop_dly,
    input  logic               cfg_tdp_hi,
    output logic               mild_on,
    output logic               sev_on,
    output logic [1:0]         freq_req,
    output logic               vdrop_req
);

    freq_req_e freq_d;

    thr_level #(
        .PWR_W  (PWR_W),
        .DWELL_W(DWELL_W),
        .BAND_LO(MILD_BAND_STD),
        .BAND_HI(MILD_BAND_HI)
    ) u_mild (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .pwr     (smp_pwr),
        .thr     (cfg_mild_thr),
        .dwell   (cfg_mild_dwell),
        .band_sel(cfg_tdp_hi),
        .active  (mild_on)
    );

    thr_level #(
        .PWR_W  (PWR_W),
        .DWELL_W(DWELL_W),
        .BAND_LO(SEV_BAND),
        .BAND_HI(SEV_BAND)
    ) u_sev (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .pwr     (smp_pwr),
        .thr     (cfg_sev_thr),
        .dwell   (cfg_sev_dwell),
        .band_sel(1'b0),
        .active  (sev_on)
    );

    vdrop_timer #(
        .DWELL_W(DWELL_W)
    ) u_vdrop (
        .clk   (clk),
        .rst   (rst),
        .valid (smp_valid),
        .sev_on(sev_on),
        .dly   (cfg_vdrop_dly),
        .req   (vdrop_req)
    );

    always_comb begin
        if (sev_on) begin
            freq_d = FREQ_MINIMUM;
        end else if (mild_on) begin
            freq_d = FREQ_STEP;
        end else begin
            freq_d = FREQ_NOMINAL;
        end
    end

    assign freq_req = freq_d;

    // R7: minimum-frequency request only while severe is engaged
    a_r7_min_needs_sev: assert property (@(posedge clk) disable iff (rst)
        (freq_req == 2'b10) |-> sev_on);

    // R7: nominal request only when neither level is engaged
    a_r7_nominal_idle: assert property (@(posedge clk) disable iff (rst)
        (freq_req == 2'b00) |-> (!sev_on && !mild_on));

    // R8: voltage request never outlives the severe throttle
    a_r8_vdrop_needs_sev: assert property (@(posedge clk) disable iff (rst)
        vdrop_req |-> sev_on);

    // R1: reset leaves every output idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!mild_on && !sev_on && !vdrop_req));

endmodule

// File: tb/sim_pwr_throttle_mon.sv
module sim_pwr_throttle_mon;

    localparam int PWR_W   = 10;
    localparam int DWELL_W = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic [PWR_W-1:0]   smp_pwr = '0;
    logic [PWR_W-1:0]   cfg_mild_thr = 10'd200;
    logic [PWR_W-1:0]   cfg_sev_thr = 10'd250;
    logic [DWELL_W-1:0] cfg_mild_dwell = 5'd6;
    logic [DWELL_W-1:0] cfg_sev_dwell = 5'd3;
    logic [DWELL_W-1:0] cfg_vdrop_dly = 5'd4;
    logic               cfg_tdp_hi = 1'b0;
    logic               mild_on, sev_on, vdrop_req;
    logic [1:0]         freq_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural reference state
    bit m_mild, m_sev, m_vhit;
    int m_mcnt, m_scnt, m_vcnt;

    pwr_throttle_mon #(.PWR_W(PWR_W), .DWELL_W(DWELL_W)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pwr(smp_pwr),
        .cfg_mild_thr(cfg_mild_thr), .cfg_sev_thr(cfg_sev_thr),
        .cfg_mild_dwell(cfg_mild_dwell), .cfg_sev_dwell(cfg_sev_dwell),
        .cfg_vdrop_dly(cfg_vdrop_dly), .cfg_tdp_hi(cfg_tdp_hi),
        .mild_on(mild_on), .sev_on(sev_on), .freq_req(freq_req),
        .vdrop_req(vdrop_req)
    );

    always #10 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void lvl_upd(ref bit act, ref int cnt, input int p,
                                    input int thr, input int dw, input int band);
        int need = (dw == 0) ? 1 : dw;
        int rel  = (thr > band) ? thr - band : 0;
        if (!act) begin
            if (p > thr) begin
                if (cnt + 1 >= need) begin act = 1; cnt = 0; end
                else cnt = cnt + 1;
            end else cnt = 0;
        end else begin
            cnt = 0;
            if (p <= rel) act = 0;
        end
    endfunction

    function automatic void model_edge();
        bit sev_old = m_sev;
        if (rst) begin
            m_mild = 0; m_sev = 0; m_vhit = 0;
            m_mcnt = 0; m_scnt = 0; m_vcnt = 0;
            return;
        end
        if (!sev_old) begin
            m_vhit = 0; m_vcnt = 0;
        end else if (smp_valid && !m_vhit) begin
            if (m_vcnt + 1 >= ((cfg_vdrop_dly == 0) ? 1 : int'(cfg_vdrop_dly))) m_vhit = 1;
            else m_vcnt = m_vcnt + 1;
        end
        if (smp_valid) begin
            lvl_upd(m_mild, m_mcnt, int'(smp_pwr), int'(cfg_mild_thr),
                    int'(cfg_mild_dwell), cfg_tdp_hi ? 20 : 15);
            lvl_upd(m_sev, m_scnt, int'(smp_pwr), int'(cfg_sev_thr),
                    int'(cfg_sev_dwell), 40);
        end
    endfunction

    task automatic step(int p, bit v);
        int fexp;
        @(negedge clk);
        smp_pwr   = PWR_W'(p);
        smp_valid = v;
        @(posedge clk);
        model_edge();
        #1;
        fexp = m_sev ? 2 : (m_mild ? 1 : 0);
        check("R2/R3 mild_on", int'(mild_on), int'(m_mild));
        check("R4/R5 sev_on", int'(sev_on), int'(m_sev));
        check("R7 freq_req", int'(freq_req), fexp);
        check("R8 vdrop_req", int'(vdrop_req), int'(m_vhit && m_sev));
    endtask

    task automatic run(int p, int n);
        for (int i = 0; i < n; i++) step(p, 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        step(0, 1'b0);
        step(300, 1'b1);
        rst = 1'b0;
        // R1: reset state
        check("R1 mild_on", int'(mild_on), 0);
        check("R1 sev_on", int'(sev_on), 0);
        check("R1 freq_req", int'(freq_req), 0);
        check("R1 vdrop_req", int'(vdrop_req), 0);

        // R6: five readings above, one at threshold, restart
        run(210, 5);
        step(200, 1'b1);
        check("R6 count restarted", int'(mild_on), 0);
        run(210, 5);
        check("R2 not before dwell", int'(mild_on), 0);
        step(210, 1'b1);
        check("R2 mild engaged", int'(mild_on), 1);
        check("R7 step-down code", int'(freq_req), 1);

        // R9: idle cycles with low power change nothing
        for (int i = 0; i < 4; i++) step(0, 1'b0);
        check("R9 idle ignored", int'(mild_on), 1);

        // R3: standard class band of 15 W
        step(186, 1'b1);
        check("R3 hold above 185", int'(mild_on), 1);
        step(185, 1'b1);
        check("R3 release at 185", int'(mild_on), 0);

        // R3: high class band of 20 W
        cfg_tdp_hi = 1'b1;
        run(210, 6);
        check("R2 mild re-engaged", int'(mild_on), 1);
        step(181, 1'b1);
        check("R3 hold above 180", int'(mild_on), 1);
        step(180, 1'b1);
        check("R3 release at 180", int'(mild_on), 0);
        cfg_tdp_hi = 1'b0;

        // R4 / R7 / R8: severe level and voltage request
        run(260, 2);
        check("R4 not before dwell", int'(sev_on), 0);
        step(260, 1'b1);
        check("R4 severe engaged", int'(sev_on), 1);
        check("R7 minimum code", int'(freq_req), 2);
        run(260, 3);
        check("R8 not before delay", int'(vdrop_req), 0);
        check("R7 severe over mild", int'(freq_req), 2);
        step(0, 1'b0);
        check("R9 delay frozen", int'(vdrop_req), 0);
        step(260, 1'b1);
        check("R8 voltage request", int'(vdrop_req), 1);

        // R5 / R8: severe band of 40 W, request follows release
        step(215, 1'b1);
        check("R5 hold above 210", int'(sev_on), 1);
        step(210, 1'b1);
        check("R5 release at 210", int'(sev_on), 0);
        check("R8 drops with severe", int'(vdrop_req), 0);
        check("R7 back to step-down", int'(freq_req), 1);
        run(100, 2);
        check("R7 nominal", int'(freq_req), 0);

        // R10: zero dwell and zero delay act as one
        cfg_sev_dwell = '0;
        cfg_vdrop_dly = '0;
        step(300, 1'b1);
        check("R10 zero dwell", int'(sev_on), 1);
        step(300, 1'b1);
        check("R10 zero delay", int'(vdrop_req), 1);
        run(100, 1);
        check("R5 release", int'(sev_on), 0);

        // R1: reset while engaged
        run(300, 7);
        rst = 1'b1;
        step(300, 1'b1);
        rst = 1'b0;
        check("R1 reset clears mild", int'(mild_on), 0);
        check("R1 reset clears severe", int'(sev_on), 0);
        check("R1 reset clears request", int'(vdrop_req), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule